// File: doc/BRIEF.md
# Bit Field Extract Insert Unit

This unit handles bit fields inside a container word, described by a width and an offset. It can extract a field and return it zero-extended or sign-extended. It can also insert the low bits of a value into the field's position and return the whole updated container. The container is either one 64-bit word or a pair of 64-bit words, with the upper word above the lower one. In the pair case a field of up to 64 bits may cross the boundary between the words. Such a field goes through the same shift path as any other field; there is no separate case for it.

An operation is presented for one cycle with a strobe. The unit captures the result in registers and raises a valid flag on the next cycle. A new operation may be issued on every cycle. The width and offset come in a descriptor, which has a full form and a compact immediate form.

Top module: `bfx_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, res_valid_o is 0 and both result words are 0.
- R2: An operation strobed on op_valid_i in one cycle shows its result on res_lo_o and res_hi_o, with res_valid_o high, after the next rising clock edge. res_valid_o is low after any edge at which the strobe was low.
- R3: When the strobe is low, both result words keep their values, even if every other input changes.
- R4: With compact_i low, desc_i[6:0] is the offset (0 to 127) and desc_i[12:7] is a width code. Code 0 means a width of 64, and any other code is the width itself.
- R5: With compact_i high, desc_i[5:0] is the offset (0 to 63) and desc_i[9:6] is a width code, where 0 means 16 and any other code is the width. desc_i[12:10] has no effect in this form.
- R6: op_i = 0 is an unsigned extract. res_lo_o bit i is container bit (offset+i) for i below the width, and 0 above it. res_hi_o is 0.
- R7: op_i = 1 is a signed extract. It gives the same field as R6, but every res_lo_o bit from the width up to 63 copies field bit (width-1). res_hi_o is 0.
- R8: With dbl_i high the container is {hi_i, lo_i} (128 bits), and a field that crosses bit 63/64 takes its upper bits from hi_i. With dbl_i low the container is lo_i alone. In both cases, container positions past the top read as 0.
- R9: op_i = 2 or 3 is an insert. Container bits offset to offset+width-1 take the low bits of ins_i, and all other bits keep their values. Positions past the container top are dropped. The result is {res_hi_o, res_lo_o} when dbl_i is high. When dbl_i is low, the result is res_lo_o and res_hi_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 unsigned extract, 1 signed extract, 2/3 insert |
| dbl_i | input | 1 | 1 selects the two-word container |
| compact_i | input | 1 | 1 selects the compact descriptor form |
| desc_i | input | 13 | Width and offset descriptor |
| lo_i | input | 64 | Lower container word |
| hi_i | input | 64 | Upper container word |
| ins_i | input | 64 | Value to insert |
| res_valid_o | output | 1 | Result valid, one cycle after the strobe |
| res_lo_o | output | 64 | Extracted field or lower result word |
| res_hi_o | output | 64 | Upper result word (insert only) |

## Verification
The case that matters most is when a straddling field and sign extension fall in the same cycle. That happens in a two-word signed extract whose field crosses bit 63 and whose top bit therefore comes from hi_i. A second such case is an insert whose field runs past the top of the container, where truncation and replacement happen together. The bench provokes both by sweeping every width from 1 to 64 against every offset, in both container modes and for every operation, with random container data. It judges each result against a bit-by-bit reference written from the requirements.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [1:0] {
    BFX_EXT_U   = 2'b00,
    BFX_EXT_S   = 2'b01,
    BFX_INS     = 2'b10,
    BFX_INS_ALT = 2'b11
  } bfx_op_e;

  function automatic logic op_is_insert(input bfx_op_e op);
    return (op == BFX_INS) || (op == BFX_INS_ALT);
  endfunction
endpackage

// File: rtl/bfx_desc_dec.sv
module bfx_desc_dec #(
  parameter int DW        = 64,
  parameter int CMP_WID_W = 4,
  localparam int OFF_W  = $clog2(2*DW),
  localparam int WC_W   = $clog2(DW),
  localparam int WID_W  = $clog2(DW) + 1,
  localparam int DESC_W = OFF_W + WC_W
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic              compact_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [WID_W-1:0]  wid_o
);
  logic [WC_W-1:0]      full_code;
  logic [CMP_WID_W-1:0] cmp_code;

  assign full_code = desc_i[OFF_W +: WC_W];
  assign cmp_code  = desc_i[WC_W +: CMP_WID_W];

  always_comb begin
    if (compact_i) begin
      off_o = OFF_W'(desc_i[WC_W-1:0]);
      wid_o = (cmp_code == '0) ? WID_W'(2**CMP_WID_W) : WID_W'(cmp_code);
    end else begin
      off_o = desc_i[OFF_W-1:0];
      wid_o = (full_code == '0) ? WID_W'(DW) : WID_W'(full_code);
    end
  end
endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
  parameter int DW = 64,
  localparam int WID_W = $clog2(DW) + 1
) (
  input  logic [WID_W-1:0] wid_i,
  output logic [DW-1:0]    mask_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign mask_o[i] = (WID_W'(i) < wid_i);
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DW = 64,
  localparam int OFF_W = $clog2(2*DW),
  localparam int WID_W = $clog2(DW) + 1
) (
  input  logic [2*DW-1:0]  cont_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic [DW-1:0]    mask_i,
  input  logic             sign_i,
  output logic [DW-1:0]    field_o
);
  logic [DW-1:0]    raw;
  logic [DW-1:0]    unsig;
  logic [DW-1:0]    up;
  logic [WID_W-1:0] excess;

  // One right shift across the whole pair covers straddling fields too.
  assign raw    = DW'(cont_i >> off_i);
  assign unsig  = raw & mask_i;
  // Shift the field's top bit up to the MSB, then arithmetic shift back down.
  assign excess = WID_W'(DW) - wid_i;
  assign up     = unsig << excess;
  assign field_o = sign_i ? DW'($signed(up) >>> excess) : unsig;
endmodule

// File: rtl/bfx_insert.sv
module bfx_insert #(
  parameter int DW = 64,
  localparam int OFF_W = $clog2(2*DW)
) (
  input  logic [2*DW-1:0]  cont_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [DW-1:0]    mask_i,
  input  logic [DW-1:0]    val_i,
  output logic [2*DW-1:0]  cont_o
);
  logic [2*DW-1:0] hole;
  logic [2*DW-1:0] fill;

  // Bits shifted past the pair's top fall off, which is the truncation rule.
  assign hole   = (2*DW)'(mask_i) << off_i;
  assign fill   = (2*DW)'(val_i & mask_i) << off_i;
  assign cont_o = (cont_i & ~hole) | fill;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DW        = 64,
  parameter int CMP_WID_W = 4,
  localparam int OFF_W  = $clog2(2*DW),
  localparam int WID_W  = $clog2(DW) + 1,
  localparam int DESC_W = OFF_W + $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic              dbl_i,
  input  logic              compact_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [DW-1:0]     lo_i,
  input  logic [DW-1:0]     hi_i,
  input  logic [DW-1:0]     ins_i,
  output logic              res_valid_o,
  output logic [DW-1:0]     res_lo_o,
  output logic [DW-1:0]     res_hi_o
);
  import bfx_pkg::*;

  bfx_op_e         op;
  logic            do_ins;
  logic [OFF_W-1:0] off;
  logic [WID_W-1:0] wid;
  logic [DW-1:0]   mask;
  logic [2*DW-1:0] cont;
  logic [DW-1:0]   field;
  logic [2*DW-1:0] merged;
  logic [DW-1:0]   nxt_lo;
  logic [DW-1:0]   nxt_hi;

  assign op     = bfx_op_e'(op_i);
  assign do_ins = op_is_insert(op);
  assign cont   = dbl_i ? {hi_i, lo_i} : {{DW{1'b0}}, lo_i};

  bfx_desc_dec #(.DW(DW), .CMP_WID_W(CMP_WID_W)) dec_i (
    .desc_i(desc_i), .compact_i(compact_i), .off_o(off), .wid_o(wid)
  );

  bfx_mask_gen #(.DW(DW)) mask_i0 (.wid_i(wid), .mask_o(mask));

  bfx_extract #(.DW(DW)) ext_i (
    .cont_i(cont), .off_i(off), .wid_i(wid), .mask_i(mask),
    .sign_i(op == BFX_EXT_S), .field_o(field)
  );

  bfx_insert #(.DW(DW)) ins_i0 (
    .cont_i(cont), .off_i(off), .mask_i(mask), .val_i(ins_i), .cont_o(merged)
  );

  always_comb begin
    if (do_ins) begin
      nxt_lo = merged[DW-1:0];
      nxt_hi = dbl_i ? merged[2*DW-1:DW] : '0;
    end else begin
      nxt_lo = field;
      nxt_hi = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_lo_o    <= '0;
      res_hi_o    <= '0;
    end else begin
      res_valid_o <= op_valid_i;
      if (op_valid_i) begin
        res_lo_o <= nxt_lo;
        res_hi_o <= nxt_hi;
      end
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid_i |=> res_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> !res_valid_o);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> ($stable(res_lo_o) && $stable(res_hi_o)));
  assert_ext_hi_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !op_i[1]) |=> (res_hi_o == '0));
  assert_single_hi_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !dbl_i) |=> (res_hi_o == '0));
endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [1:0]  op = '0;
  logic        dbl = 1'b0;
  logic        compact = 1'b0;
  logic [12:0] desc = '0;
  logic [63:0] lo = '0, hi = '0, ins = '0;
  logic        res_valid;
  logic [63:0] res_lo, res_hi;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bfx_unit dut_i (
    .clk(clk), .rst(rst), .op_valid_i(op_valid), .op_i(op), .dbl_i(dbl),
    .compact_i(compact), .desc_i(desc), .lo_i(lo), .hi_i(hi), .ins_i(ins),
    .res_valid_o(res_valid), .res_lo_o(res_lo), .res_hi_o(res_hi)
  );

  function automatic logic [127:0] ref_calc(input logic [1:0] o, input logic d,
      input logic [63:0] l, input logic [63:0] h, input logic [63:0] v,
      input int off, input int w);
    logic [127:0] c;
    logic [127:0] r;
    logic [63:0]  f;
    int cw;
    cw = d ? 128 : 64;
    c  = d ? {h, l} : {64'd0, l};
    if (o[1]) begin
      r = c;
      for (int i = 0; i < w; i++)
        if (off + i < cw) r[off+i] = v[i];
      return r;
    end
    f = '0;
    for (int i = 0; i < w; i++)
      if (off + i < cw) f[i] = c[off+i];
    if (o == 2'd1)
      for (int i = w; i < 64; i++) f[i] = f[w-1];
    return {64'd0, f};
  endfunction

  task automatic check(input string tag, input logic [127:0] exp, input logic exp_v);
    total++;
    if (res_valid !== exp_v || {res_hi, res_lo} !== exp) begin
      bad++;
      $display("FAIL %s: got v=%0b hi=%h lo=%h exp v=%0b hi=%h lo=%h",
               tag, res_valid, res_hi, res_lo, exp_v, exp[127:64], exp[63:0]);
    end
  endtask

  // Caller is at a falling edge: drive, wait one cycle, check.
  task automatic run_op(input logic [1:0] o, input logic d, input logic cmp,
      input logic [12:0] ds, input int off, input int w, input string tag);
    logic [127:0] exp;
    op = o; dbl = d; compact = cmp; desc = ds;
    lo = {$urandom, $urandom}; hi = {$urandom, $urandom}; ins = {$urandom, $urandom};
    op_valid = 1'b1;
    exp = ref_calc(o, d, lo, hi, ins, off, w);
    @(negedge clk);
    check(tag, exp, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    string tag;
    void'($urandom(7));
    op_valid = 1'b1; lo = '1; hi = '1; ins = '1; desc = 13'h1fff;
    repeat (3) @(negedge clk);
    check("R1 in reset", 128'd0, 1'b0);
    rst = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    check("R1 after reset", 128'd0, 1'b0);

    // Full descriptor sweep: every width, every offset, every op, both modes (R4).
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++)
        for (int w = 1; w <= 64; w++)
          for (int off = 0; off < (d ? 128 : 64); off++) begin
            logic [1:0] oc;
            oc = (k == 2) ? (2'd2 | 2'(w & 1)) : 2'(k);
            if (k == 2) tag = "R9 insert";
            else if (d == 1 && off < 64 && off + w > 64) tag = (k == 1) ? "R7 R8 signed straddle" : "R6 R8 straddle";
            else tag = (k == 1) ? "R7 signed R4" : "R6 unsigned R4";
            run_op(oc, d[0], 1'b0, {6'(w % 64), 7'(off)}, off, w, tag);
          end

    // Compact form, upper descriptor bits random (R5).
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 16; c++)
        for (int off = 0; off < 64; off++) begin
          run_op(2'(k), 1'($urandom), 1'b1, {3'($urandom), 4'(c), 6'(off)},
                 off, (c == 0) ? 16 : c, "R5 compact");
        end

    // Hold when idle while other inputs toggle (R2, R3).
    for (int n = 0; n < 8; n++) begin
      run_op(2'd2, 1'b1, 1'b0, {6'd0, 7'(n * 9)}, n * 9, 64, "R9 insert full");
      held = {res_hi, res_lo};
      op_valid = 1'b0;
      for (int m = 0; m < 2; m++) begin
        op = 2'($urandom); dbl = 1'($urandom); desc = 13'($urandom);
        lo = {$urandom, $urandom}; hi = {$urandom, $urandom}; ins = {$urandom, $urandom};
        @(negedge clk);
        check("R3 R2 hold idle", held, 1'b0);
      end
    end

    // Reset mid-stream with strobe high (R1).
    op_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", 128'd0, 1'b0);
    rst = 1'b0; op_valid = 1'b0;
    @(negedge clk);
    check("R1 post reset", 128'd0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule